// File: doc/BRIEF.md
# 24-Hour Time-of-Day Clock

This block keeps the time of day as hours, minutes and seconds in BCD and drives six active-low seven-segment digit outputs, two per field. A free-running system clock is divided down to a one-second enable. Each enable advances the seconds. A seconds rollover advances the minutes, and a minute rollover advances the hours. The hours wrap from 23 to 00, so 23:59:59 is followed by 00:00:00.

A 16-bit switch word sets the time. When the load control is high at a clock edge, the hours and minutes take the switch value, the seconds become 00 and the one-second divider starts its count again. An active-low asynchronous reset sets the time to 00:00:00. The divider terminal count is a parameter. Its default suits a 50 MHz clock, and a small value makes simulation runs short.

Top module: `tod_clock`

## Requirements
- R1: While `rst_n` is low the time is 00:00:00 and the divider is cleared. The reset acts asynchronously, so every digit output shows "0" without waiting for a clock edge.
- R2: After reset release or a load, the seconds advance once every TICK_LAST+1 clock cycles. The first advance happens on the (TICK_LAST+1)-th rising edge, and between advances the digits hold.
- R3: The seconds count from 00 to 59. An advance at 59 gives 00 and moves the minutes on by one in the same edge.
- R4: The minutes count from 00 to 59. A minute rollover at 59 gives 00 and moves the hours on by one in the same edge.
- R5: The hours count from 00 to 23. The advance after 23:59:59 gives 00:00:00.
- R6: When `preset_load` is high at a rising edge, the hours take `preset_sw[15:8]` (tens in [15:12], ones in [11:8]) and the minutes take `preset_sw[7:0]` (tens in [7:4], ones in [3:0]). The seconds become 00 and the divider restarts, so the next advance comes TICK_LAST+1 edges later.
- R7: A load on the same edge as a one-second advance wins, and the seconds read 00 after that edge.
- R8: Segment outputs are active-low, ordered {g,f,e,d,c,b,a} with segment a in bit 0. The active-high lit patterns for 0 through 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R9: A digit code from 10 to 15, which only a preset can create, shows as blank with all seven outputs high.
- R10: Within a field, a ones digit of 9 rolls to 0 and carries into the tens digit (for example 09 to 10, and hours 19 to 20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| preset_sw | input | 16 | Preset word: BCD hours [15:8], BCD minutes [7:0] |
| preset_load | input | 1 | Load the preset at the next rising edge |
| seg_hr_tens | output | 7 | Hours tens digit, active-low segments |
| seg_hr_ones | output | 7 | Hours ones digit, active-low segments |
| seg_min_tens | output | 7 | Minutes tens digit, active-low segments |
| seg_min_ones | output | 7 | Minutes ones digit, active-low segments |
| seg_sec_tens | output | 7 | Seconds tens digit, active-low segments |
| seg_sec_ones | output | 7 | Seconds ones digit, active-low segments |

## Verification
Every output is a decode of a registered digit, so a wrong digit register shows at the segment ports in the same cycle it goes wrong. A fault in the divider shows differently: it shifts when the seconds digit moves, and the error appears one second-period later as an advance that comes early or late. Carry faults only show at the 59 and 23 boundaries, and those are reached quickly through presets. A model that runs cycle by cycle is compared on every clock, so the first differing cycle is reported.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef logic [DIGIT_W-1:0]   digit_t;
  typedef logic [2*DIGIT_W-1:0] pair_t;   // {tens, ones}
  typedef logic [SEG_W-1:0]     seg_t;

  // Active-low segments, bit order {g,f,e,d,c,b,a}; codes above 9 blank.
  function automatic seg_t digit_to_seg(input digit_t d);
    seg_t lit;
    case (d)
      4'd0:    lit = 7'h3F;
      4'd1:    lit = 7'h06;
      4'd2:    lit = 7'h5B;
      4'd3:    lit = 7'h4F;
      4'd4:    lit = 7'h66;
      4'd5:    lit = 7'h6D;
      4'd6:    lit = 7'h7D;
      4'd7:    lit = 7'h07;
      4'd8:    lit = 7'h7F;
      4'd9:    lit = 7'h6F;
      default: lit = 7'h00;
    endcase
    return ~lit;
  endfunction

  // Next value of a two-digit BCD field whose last value is 'last'.
  function automatic pair_t pair_advance(input pair_t cur, input pair_t last);
    digit_t tens;
    digit_t ones;
    tens = cur[2*DIGIT_W-1:DIGIT_W];
    ones = cur[DIGIT_W-1:0];
    if (cur == last) begin
      return '0;
    end
    if (ones >= 4'd9) begin
      return {tens + 4'd1, 4'd0};
    end
    return {tens, ones + 4'd1};
  endfunction

endpackage

// File: rtl/tod_tick_gen.sv
module tod_tick_gen #(
  parameter int unsigned TICK_LAST = 49_999_999
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICK_LAST > 0) ? $clog2(TICK_LAST + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_LAST);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R6

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !restart && !tick |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

  generate
    if (TICK_LAST > 0) begin : g_spacing
      AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate

endmodule

// File: rtl/tod_bcd_pair.sv
module tod_bcd_pair
  import tod_pkg::*;
#(
  parameter logic [7:0] LAST_BCD = 8'h59
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc,
  input  logic  load,
  input  pair_t load_val,
  output pair_t val,
  output logic  wrap
);
  pair_t val_q;

  assign val  = val_q;
  assign wrap = inc && !load && (val_q == LAST_BCD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load) begin
      val_q <= load_val;
    end else if (inc) begin
      val_q <= pair_advance(val_q, LAST_BCD);
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val_q == $past(load_val))); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (val_q == '0)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !load |=> $stable(val_q)); // R2

  AST_ONES_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && (val_q[3:0] == 4'd9) && (val_q != LAST_BCD)
    |=> (val_q[3:0] == 4'd0) && (val_q[7:4] == $past(val_q[7:4]) + 4'd1)); // R10

endmodule

// File: rtl/tod_seg_bank.sv
module tod_seg_bank
  import tod_pkg::*;
#(
  parameter int N_DIGITS = 6
) (
  input  digit_t [N_DIGITS-1:0] digits,
  output seg_t   [N_DIGITS-1:0] segs
);
  generate
    for (genvar g = 0; g < N_DIGITS; g++) begin : g_dec
      assign segs[g] = digit_to_seg(digits[g]);
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < N_DIGITS; k++) begin
      AST_BLANK_CODES: assert ((digits[k] <= 4'd9) || (segs[k] == 7'h7F)); // R9
    end
  end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int unsigned TICK_LAST = 49_999_999
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] preset_sw,
  input  logic        preset_load,
  output logic [6:0]  seg_hr_tens,
  output logic [6:0]  seg_hr_ones,
  output logic [6:0]  seg_min_tens,
  output logic [6:0]  seg_min_ones,
  output logic [6:0]  seg_sec_tens,
  output logic [6:0]  seg_sec_ones
);
  localparam int N_DIGITS = 6;

  // Internal events, named for the checks.
  logic  sec_tick;
  logic  sec_wrap;
  logic  min_wrap;
  logic  hr_wrap;
  pair_t sec_bcd;
  pair_t min_bcd;
  pair_t hr_bcd;

  digit_t [N_DIGITS-1:0] digits;
  seg_t   [N_DIGITS-1:0] segs;

  tod_tick_gen #(.TICK_LAST(TICK_LAST)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (preset_load),
    .tick    (sec_tick)
  );

  tod_bcd_pair #(.LAST_BCD(8'h59)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (sec_tick),
    .load     (preset_load),
    .load_val (8'h00),
    .val      (sec_bcd),
    .wrap     (sec_wrap)
  );

  tod_bcd_pair #(.LAST_BCD(8'h59)) u_min (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (sec_wrap),
    .load     (preset_load),
    .load_val (preset_sw[7:0]),
    .val      (min_bcd),
    .wrap     (min_wrap)
  );

  tod_bcd_pair #(.LAST_BCD(8'h23)) u_hr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (min_wrap),
    .load     (preset_load),
    .load_val (preset_sw[15:8]),
    .val      (hr_bcd),
    .wrap     (hr_wrap)
  );

  assign digits = {hr_bcd, min_bcd, sec_bcd};

  tod_seg_bank #(.N_DIGITS(N_DIGITS)) u_segs (
    .digits (digits),
    .segs   (segs)
  );

  assign seg_hr_tens  = segs[5];
  assign seg_hr_ones  = segs[4];
  assign seg_min_tens = segs[3];
  assign seg_min_ones = segs[2];
  assign seg_sec_tens = segs[1];
  assign seg_sec_ones = segs[0];

  AST_SEC_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> (sec_bcd == 8'h00)); // R6

  AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load && sec_tick |=> (sec_bcd == 8'h00)); // R7

  AST_MIN_CARRY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |-> (sec_bcd == 8'h59)); // R3

  AST_HR_CARRY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap && (min_bcd == 8'h59) |-> min_wrap); // R4

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    hr_wrap |=> (hr_bcd == 8'h00) && (min_bcd == 8'h00) && (sec_bcd == 8'h00)); // R5

endmodule

// File: tb/test_tod_clock.sv
module test_tod_clock;
  localparam int TL  = 3;
  localparam int SPS = TL + 1;   // cycles per second

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] sw = '0;
  logic        ld = 1'b0;
  logic [6:0]  s_ht, s_ho, s_mt, s_mo, s_st, s_so;

  always #4 clk = ~clk;

  tod_clock #(.TICK_LAST(TL)) i_tod_clock (
    .clk          (clk),
    .rst_n        (rst_n),
    .preset_sw    (sw),
    .preset_load  (ld),
    .seg_hr_tens  (s_ht),
    .seg_hr_ones  (s_ho),
    .seg_min_tens (s_mt),
    .seg_min_ones (s_mo),
    .seg_sec_tens (s_st),
    .seg_sec_ones (s_so)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Lit segment masks 0..9, active-high, a in bit 0.
  localparam logic [6:0] LIT [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                      7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  function automatic logic [6:0] want(input int d);
    if (d < 0 || d > 9) return 7'h7F;
    return ~LIT[d];
  endfunction

  // Behavioural reference: digits as integers, seconds as a plain count.
  int m_ht, m_ho, m_mt, m_mo, m_sc, m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ht = 0; m_ho = 0; m_mt = 0; m_mo = 0; m_sc = 0; m_div = 0;
    end else if (ld) begin
      m_ht = sw[15:12]; m_ho = sw[11:8]; m_mt = sw[7:4]; m_mo = sw[3:0];
      m_sc = 0; m_div = 0;
    end else if (m_div == TL) begin
      int mins, hrs;
      m_div = 0;
      m_sc++;
      if (m_sc == 60) begin
        m_sc = 0;
        mins = m_mt * 10 + m_mo + 1;
        if (mins == 60) begin
          mins = 0;
          hrs = m_ht * 10 + m_ho;
          hrs = (hrs == 23) ? 0 : hrs + 1;
          m_ht = hrs / 10; m_ho = hrs % 10;
        end
        m_mt = mins / 10; m_mo = mins % 10;
      end
    end else begin
      m_div++;
    end
  end

  // Per-cycle comparison against the model (R2 timing, all fields).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({s_ht, s_ho, s_mt, s_mo, s_st, s_so} !==
          {want(m_ht), want(m_ho), want(m_mt), want(m_mo), want(m_sc / 10), want(m_sc % 10)}) begin
        fails++;
        $display("FAIL R2 model compare t=%0t actual=%h %h %h %h %h %h expected=%h %h %h %h %h %h",
                 $time, s_ht, s_ho, s_mt, s_mo, s_st, s_so,
                 want(m_ht), want(m_ho), want(m_mt), want(m_mo), want(m_sc / 10), want(m_sc % 10));
      end
    end
  end

  task automatic expect_time(input string req, input int ht, ho, mt, mo, st, so);
    logic [41:0] act, exp;
    act = {s_ht, s_ho, s_mt, s_mo, s_st, s_so};
    exp = {want(ht), want(ho), want(mt), want(mo), want(st), want(so)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (digits %0d%0d:%0d%0d:%0d%0d)",
               req, act, exp, ht, ho, mt, mo, st, so);
    end
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    sw = v; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic run_secs(input int n);
    repeat (n * SPS) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    #1 expect_time("R1 reset state", 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: first advance on the 4th edge after release
    repeat (SPS - 1) @(negedge clk);
    expect_time("R2 before first tick", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    expect_time("R2 first tick", 0, 0, 0, 0, 0, 1);

    // R3: seconds wrap with minute carry
    run_secs(69);
    expect_time("R3 seconds wrap", 0, 0, 0, 1, 1, 0);

    // R6: preset, seconds cleared, divider restarted
    run_secs(1); repeat (2) @(negedge clk);
    load(16'h1234);
    expect_time("R6 preset value", 1, 2, 3, 4, 0, 0);
    repeat (SPS - 1) @(negedge clk);
    expect_time("R6 divider restart hold", 1, 2, 3, 4, 0, 0);
    @(negedge clk);
    expect_time("R6 divider restart tick", 1, 2, 3, 4, 0, 1);

    // R4: minute wrap into hours
    load(16'h0059);
    run_secs(60);
    expect_time("R4 minute wrap", 0, 1, 0, 0, 0, 0);

    // R10: BCD carries in hours
    load(16'h0959);
    run_secs(60);
    expect_time("R10 hours 09 to 10", 1, 0, 0, 0, 0, 0);
    load(16'h1959);
    run_secs(60);
    expect_time("R10 hours 19 to 20", 2, 0, 0, 0, 0, 0);

    // R5: end of day
    load(16'h2359);
    run_secs(59);
    expect_time("R5 last second of day", 2, 3, 5, 9, 5, 9);
    run_secs(1);
    expect_time("R5 day wrap", 0, 0, 0, 0, 0, 0);

    // R7: load on the tick edge
    load(16'h0712);
    repeat (SPS - 1) @(negedge clk);
    sw = 16'h1545; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
    expect_time("R7 load beats tick", 1, 5, 4, 5, 0, 0);

    // R8: decode of every digit value
    load(16'h8967);
    expect_time("R8 digits 8 9 6 7 0", 8, 9, 6, 7, 0, 0);
    load(16'h1234);
    run_secs(5);
    expect_time("R8 digits 1 2 3 4 5", 1, 2, 3, 4, 0, 5);

    // R9: codes above nine blank
    load(16'hAFC5);
    expect_time("R9 blank codes", 10, 15, 12, 5, 0, 0);

    // R1: asynchronous reset mid-run
    run_secs(2);
    #2 rst_n = 1'b0;
    #1 expect_time("R1 async reset", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_secs(3);
    expect_time("R2 after second reset", 0, 0, 0, 0, 0, 3);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule